// File: doc/BRIEF.md
# Banked Storage Read/Write Crossbar

This block connects a set of synchronous storage banks to a group of read ports and a group of write ports. Each bank holds 1024 words of 64 bits. Every port names a target bank with a 5-bit select and gives a 10-bit word address; write ports also give a 64-bit data word. The crossbar decodes each select into one chip-select line per bank. It steers the addresses and the write data into the chosen banks, and it returns the chosen bank's read word to each read port.

The steering logic is a gated OR and not an arbitrated bus. Each chip select gates its port's address or data, the gated terms are combined in groups of three, and the group results are OR-reduced. For this to give sensible results, at most one port may target a given bank in any cycle. The schedule that feeds the ports must ensure this. The crossbar does not resolve such a clash: it reports it through a per-bank conflict flag. A select value equal to or above the number of banks addresses nothing. The bank count, the read-port count and the write-port count are parameters.

Top module: `xbar_crossbar`

## Requirements
- R1: A write port whose select equals bank index b (0 to NUM_BANKS-1) stores its data at its address in bank b at the clock edge. Every address from 0 to 1023 can be written and read back unchanged.
- R2: A read port that presents select b and an address before clock edge k sees that word of bank b on its data output after edge k and until edge k+1. Before edge k the output does not follow the new request. After a cycle in which the port was idle, its output is zero.
- R3: A select value equal to or above NUM_BANKS (for example 3 or 31 with three banks) is idle. A write with such a select changes no bank, and a read with such a select returns all zeros in the following cycle.
- R4: Read ports that target different banks in the same cycle each receive their own bank's word in the following cycle.
- R5: Write ports that target different banks in the same cycle all store their data in that cycle.
- R6: Conflict bit b is high during the cycle after an edge at which two or more ports (read or write, in any mix) selected bank b. It is low after an edge at which zero or one port selected bank b.
- R7: After a clock edge with reset high, every read data output and every conflict bit is zero.
- R8: A bank's write enable is active only at an edge at which some write port selects that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | NUM_RD*5 | Bank select of each read port |
| rd_addr | input | NUM_RD*10 | Word address of each read port |
| rd_data | output | NUM_RD*64 | Returned word of each read port, one cycle after its request |
| wr_sel | input | NUM_WR*5 | Bank select of each write port |
| wr_addr | input | NUM_WR*10 | Word address of each write port |
| wr_data | input | NUM_WR*64 | Data word of each write port |
| bank_conflict | output | NUM_BANKS | Per-bank flag: two or more ports selected the bank at the previous edge |

## Verification
Some faults in the select decode or in the gating groups write a word into the wrong bank or at the wrong address. They are seen only later, when a read of that location returns a wrong word or a neighbouring location turns out changed. The tests therefore read back every location they touched, plus locations an idle write might have hit. A fault in the registered read select shows up in the first cycle after a request, as data from the wrong bank or as a non-zero word for an idle port. A fault in the conflict register shows up one cycle after the colliding selects.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Number of three-input gated groups needed to cover n sources.
  function automatic int xbar_groups(input int n);
    return (n + 2) / 3;
  endfunction
endpackage

// File: rtl/xbar_sel_decode.sv
module xbar_sel_decode #(
  parameter int NUM_BANKS = 3,
  parameter int SEL_W     = 5
) (
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_BANKS-1:0] hit
);
  // A select at or above NUM_BANKS matches no index and so stays idle.
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      hit[b] = (sel == SEL_W'(b));
    end
  end
endmodule

// File: rtl/xbar_gate_or.sv
module xbar_gate_or #(
  parameter int N = 3,
  parameter int W = 64
) (
  input  logic [N-1:0][W-1:0] din,
  input  logic [N-1:0]        en,
  output logic [W-1:0]        dout
);
  import xbar_pkg::*;
  localparam int GROUPS = xbar_groups(N);

  logic [GROUPS-1:0][W-1:0] grp;

  // Each group gates up to three sources; the group results are OR-reduced.
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int BASE = 3 * g;
    logic [W-1:0] t0, t1, t2;
    assign t0 = din[BASE] & {W{en[BASE]}};
    if (BASE + 1 < N) begin : g_t1
      assign t1 = din[BASE+1] & {W{en[BASE+1]}};
    end else begin : g_z1
      assign t1 = '0;
    end
    if (BASE + 2 < N) begin : g_t2
      assign t2 = din[BASE+2] & {W{en[BASE+2]}};
    end else begin : g_z2
      assign t2 = '0;
    end
    assign grp[g] = t0 | t1 | t2;
  end

  always_comb begin
    dout = '0;
    for (int g = 0; g < GROUPS; g++) begin
      dout = dout | grp[g];
    end
  end
endmodule

// File: rtl/xbar_bank.sv
module xbar_bank #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single-port synchronous RAM with a registered read (read-first).
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end
endmodule

// File: rtl/xbar_crossbar.sv
module xbar_crossbar #(
  parameter int NUM_BANKS = 3,
  parameter int NUM_RD    = 3,
  parameter int NUM_WR    = 2,
  parameter int SEL_W     = 5,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_RD-1:0][SEL_W-1:0]   rd_sel,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
  input  logic [NUM_WR-1:0][SEL_W-1:0]   wr_sel,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data,
  output logic [NUM_BANKS-1:0]           bank_conflict
);
  localparam int NCTL  = NUM_RD + NUM_WR;
  localparam int CNT_W = $clog2(NCTL + 1);

  // All ports in one list: read ports first, then write ports.
  logic [NCTL-1:0][SEL_W-1:0]      sel_all;
  logic [NCTL-1:0][ADDR_W-1:0]     addr_all;
  logic [NCTL-1:0][NUM_BANKS-1:0]  cs;
  logic [NUM_BANKS-1:0][NCTL-1:0]  cs_bank;
  logic [NUM_BANKS-1:0]            bank_we;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_addr;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_wdata;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [NUM_BANKS-1:0]            conflict_d;
  logic [NUM_RD-1:0][NUM_BANKS-1:0] rd_cs_q;

  always_comb begin
    for (int r = 0; r < NUM_RD; r++) begin
      sel_all[r]  = rd_sel[r];
      addr_all[r] = rd_addr[r];
    end
    for (int w = 0; w < NUM_WR; w++) begin
      sel_all[NUM_RD+w]  = wr_sel[w];
      addr_all[NUM_RD+w] = wr_addr[w];
    end
  end

  for (genvar c = 0; c < NCTL; c++) begin : g_dec
    xbar_sel_decode #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_dec (
      .sel (sel_all[c]),
      .hit (cs[c])
    );
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int c = 0; c < NCTL; c++) begin
        cs_bank[b][c] = cs[c][b];
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = |cs_bank[b][NCTL-1:NUM_RD];

    xbar_gate_or #(.N(NCTL), .W(ADDR_W)) u_addr_mux (
      .din  (addr_all),
      .en   (cs_bank[b]),
      .dout (bank_addr[b])
    );

    xbar_gate_or #(.N(NUM_WR), .W(DATA_W)) u_wdata_mux (
      .din  (wr_data),
      .en   (cs_bank[b][NCTL-1:NUM_RD]),
      .dout (bank_wdata[b])
    );

    xbar_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[b]),
      .addr  (bank_addr[b]),
      .wdata (bank_wdata[b]),
      .rdata (bank_rdata[b])
    );

    always_comb begin
      logic [CNT_W-1:0] n_hit;
      n_hit = '0;
      for (int c = 0; c < NCTL; c++) begin
        n_hit = n_hit + CNT_W'(cs_bank[b][c]);
      end
      conflict_d[b] = (n_hit > CNT_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_conflict <= '0;
      rd_cs_q       <= '0;
    end else begin
      bank_conflict <= conflict_d;
      for (int r = 0; r < NUM_RD; r++) begin
        rd_cs_q[r] <= cs[r];
      end
    end
  end

  // Return path: the bank chosen at the previous edge drives each read port.
  for (genvar r = 0; r < NUM_RD; r++) begin : g_ret
    xbar_gate_or #(.N(NUM_BANKS), .W(DATA_W)) u_ret_mux (
      .din  (bank_rdata),
      .en   (rd_cs_q[r]),
      .dout (rd_data[r])
    );
  end
endmodule

// File: rtl/xbar_crossbar_chk.sv
module xbar_crossbar_chk #(
  parameter int NUM_BANKS = 3,
  parameter int NUM_RD    = 3,
  parameter int NUM_WR    = 2,
  parameter int SEL_W     = 5,
  parameter int DATA_W    = 64
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_RD-1:0][SEL_W-1:0]  rd_sel,
  input logic [NUM_WR-1:0][SEL_W-1:0]  wr_sel,
  input logic [NUM_RD-1:0][DATA_W-1:0] rd_data,
  input logic [NUM_BANKS-1:0]          bank_conflict,
  input logic [NUM_BANKS-1:0]          bank_we
);
  logic live_q = 1'b0;
  logic rst_q  = 1'b0;
  logic [NUM_BANKS-1:0][7:0] cnt_now, cnt_q;
  logic [NUM_BANKS-1:0]      wr_any;
  logic [NUM_RD-1:0][SEL_W-1:0] rsel_q;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      cnt_now[b] = '0;
      wr_any[b]  = 1'b0;
      for (int r = 0; r < NUM_RD; r++)
        if (rd_sel[r] == SEL_W'(b)) cnt_now[b] = cnt_now[b] + 8'd1;
      for (int w = 0; w < NUM_WR; w++)
        if (wr_sel[w] == SEL_W'(b)) begin
          cnt_now[b] = cnt_now[b] + 8'd1;
          wr_any[b]  = 1'b1;
        end
    end
  end

  always_ff @(posedge clk) begin
    live_q <= !rst;
    rst_q  <= rst;
    cnt_q  <= cnt_now;
    rsel_q <= rd_sel;
  end

  a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (rd_data == '0 && bank_conflict == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    // R6: flag matches the number of ports on the bank at the previous edge
    a_r6_conflict_match: assert property (@(posedge clk) disable iff (rst)
      live_q |-> (bank_conflict[b] == (cnt_q[b] >= 8'd2)));
    // R8: no write enable without a write port on the bank
    a_r8_we_needs_writer: assert property (@(posedge clk) disable iff (rst)
      bank_we[b] |-> wr_any[b]);
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_r
    // R3: an idle read port returns zero in the next cycle
    a_r3_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
      (live_q && rsel_q[r] >= SEL_W'(NUM_BANKS)) |-> (rd_data[r] == '0));
  end
endmodule

bind xbar_crossbar xbar_crossbar_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_RD(NUM_RD), .NUM_WR(NUM_WR),
  .SEL_W(SEL_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_sel(rd_sel), .wr_sel(wr_sel),
  .rd_data(rd_data), .bank_conflict(bank_conflict), .bank_we(bank_we)
);

// File: tb/test_xbar_crossbar.sv
`timescale 1ns/1ps
module test_xbar_crossbar;
  localparam int NB = 3, NR = 3, NW = 2;
  localparam logic [4:0] IDLE = 5'd31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NR-1:0][4:0]  rd_sel;
  logic [NR-1:0][9:0]  rd_addr;
  logic [NR-1:0][63:0] rd_data;
  logic [NW-1:0][4:0]  wr_sel;
  logic [NW-1:0][9:0]  wr_addr;
  logic [NW-1:0][63:0] wr_data;
  logic [NB-1:0]       bank_conflict;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xbar_crossbar #(.NUM_BANKS(NB), .NUM_RD(NR), .NUM_WR(NW)) i_xbar_crossbar (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_conflict(bank_conflict)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    rd_sel = {NR{IDLE}}; rd_addr = '0;
    wr_sel = {NW{IDLE}}; wr_addr = '0; wr_data = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr1(input int w, input logic [4:0] b, input logic [9:0] a, input logic [63:0] d);
    wr_sel[w] = b; wr_addr[w] = a; wr_data[w] = d;
    tick();
    idle_all();
  endtask

  task automatic rd1(input int r, input logic [4:0] b, input logic [9:0] a, output logic [63:0] d);
    rd_sel[r] = b; rd_addr[r] = a;
    tick();
    d = rd_data[r];
    idle_all();
  endtask

  task automatic t_reset();
    chk("R7 rd_data after reset", 64'(rd_data), 64'(0));
    chk("R7 conflict after reset", 64'(bank_conflict), 64'(0));
  endtask

  task automatic t_latency();
    logic [63:0] d;
    wr1(0, 5'd1, 10'd20, 64'h1122_3344_5566_7788);
    rd_sel[2] = 5'd1; rd_addr[2] = 10'd20;
    #1;
    chk("R2 no combinational follow", rd_data[2], 64'h0);
    tick();
    chk("R2 data one cycle later", rd_data[2], 64'h1122_3344_5566_7788);
    idle_all();
    tick();
    chk("R2 zero after idle cycle", rd_data[2], 64'h0);
    rd1(0, 5'd1, 10'd20, d);
    chk("R1 write then read bank1", d, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_boundary();
    logic [63:0] d;
    wr1(1, 5'd2, 10'd1023, 64'hFFFF_FFFF_FFFF_FFFF);
    wr1(0, 5'd2, 10'd0, 64'h0);
    wr1(0, 5'd0, 10'd0, 64'hA5A5_0000_5A5A_FFFF);
    wr1(1, 5'd0, 10'd1023, 64'h0123_4567_89AB_CDEF);
    rd1(1, 5'd2, 10'd1023, d); chk("R1 bank2 addr1023", d, 64'hFFFF_FFFF_FFFF_FFFF);
    rd1(1, 5'd2, 10'd0, d);    chk("R1 bank2 addr0", d, 64'h0);
    rd1(2, 5'd0, 10'd0, d);    chk("R1 bank0 addr0", d, 64'hA5A5_0000_5A5A_FFFF);
    rd1(0, 5'd0, 10'd1023, d); chk("R1 bank0 addr1023", d, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_parallel();
    wr1(0, 5'd1, 10'd7, 64'hBBBB_0000_0000_0001);
    wr_sel[0] = 5'd2; wr_addr[0] = 10'd7; wr_data[0] = 64'hCCCC_0000_0000_0002;
    wr_sel[1] = 5'd0; wr_addr[1] = 10'd7; wr_data[1] = 64'hAAAA_0000_0000_0003;
    rd_sel[0] = 5'd1; rd_addr[0] = 10'd20;
    tick();
    chk("R4 read beside two writes", rd_data[0], 64'h1122_3344_5566_7788);
    idle_all();
    rd_sel[0] = 5'd0; rd_addr[0] = 10'd7;
    rd_sel[1] = 5'd2; rd_addr[1] = 10'd7;
    rd_sel[2] = 5'd1; rd_addr[2] = 10'd7;
    tick();
    chk("R5 writer1 to bank0", rd_data[0], 64'hAAAA_0000_0000_0003);
    chk("R5 writer0 to bank2", rd_data[1], 64'hCCCC_0000_0000_0002);
    chk("R4 reader2 bank1", rd_data[2], 64'hBBBB_0000_0000_0001);
    chk("R6 no conflict on distinct banks", 64'(bank_conflict), 64'(0));
    idle_all();
    tick();
  endtask

  task automatic t_idle_sel();
    logic [63:0] d;
    wr_sel[0] = 5'd0; wr_addr[0] = 10'd5; wr_data[0] = 64'h0A;
    wr_sel[1] = 5'd1; wr_addr[1] = 10'd5; wr_data[1] = 64'h0B;
    tick(); idle_all();
    wr1(0, 5'd2, 10'd5, 64'h0C);
    wr_sel[0] = 5'd3;  wr_addr[0] = 10'd5; wr_data[0] = 64'hDEAD_BEEF_DEAD_BEEF;
    wr_sel[1] = 5'd31; wr_addr[1] = 10'd5; wr_data[1] = 64'hFEED_FEED_FEED_FEED;
    tick(); idle_all();
    rd_sel[0] = 5'd0; rd_sel[1] = 5'd1; rd_sel[2] = 5'd2;
    rd_addr[0] = 10'd5; rd_addr[1] = 10'd5; rd_addr[2] = 10'd5;
    tick();
    chk("R3 idle write leaves bank0", rd_data[0], 64'h0A);
    chk("R3 idle write leaves bank1", rd_data[1], 64'h0B);
    chk("R3 idle write leaves bank2", rd_data[2], 64'h0C);
    idle_all();
    rd1(0, 5'd3, 10'd5, d);  chk("R3 read sel 3 is zero", d, 64'h0);
    rd1(1, 5'd31, 10'd5, d); chk("R3 read sel 31 is zero", d, 64'h0);
  endtask

  task automatic t_conflict();
    rd_sel[0] = 5'd1; rd_addr[0] = 10'd7;
    rd_sel[1] = 5'd1; rd_addr[1] = 10'd7;
    tick();
    chk("R6 two readers on bank1", 64'(bank_conflict), 64'(3'b010));
    idle_all();
    rd_sel[2] = 5'd0; rd_addr[2] = 10'd7;
    tick();
    chk("R6 single reader clears flag", 64'(bank_conflict), 64'(0));
    idle_all();
    rd_sel[2] = 5'd0; rd_addr[2] = 10'd7;
    wr_sel[0] = 5'd0; wr_addr[0] = 10'd7; wr_data[0] = 64'h1;
    wr_sel[1] = 5'd2; wr_addr[1] = 10'd9; wr_data[1] = 64'h2;
    tick();
    chk("R6 reader plus writer on bank0", 64'(bank_conflict), 64'(3'b001));
    idle_all();
    tick();
    chk("R6 flag drops when idle", 64'(bank_conflict), 64'(0));
  endtask

  initial begin
    idle_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    tick();
    t_latency();
    t_boundary();
    t_parallel();
    t_idle_sel();
    t_conflict();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule